// File: doc/BRIEF.md
# Two-Bit-Opcode Accumulator Processor

This block is a small multi-cycle processor built around one 8-bit accumulator. It has a 6-bit address output and an 8-bit read-data input, so it can see 64 bytes of memory. There is no write path. Each instruction is a single byte. The two most significant bits select the operation. The six low bits name a memory location, which the operation reads as its operand.

Each instruction starts with three fetch steps. The first copies the program counter into the address register. The second reads the instruction byte and advances the program counter. The third splits the byte into the opcode and the operand address. One or two execute steps follow, and then control goes back to the first fetch step.

The four operations are:
- invert the accumulator;
- OR a memory byte into the accumulator;
- add the bitwise inverse of a memory byte to the accumulator, with no +1;
- jump relative, which adds the low six bits of a memory byte to the program counter.

The memory sits outside the block and answers a read in the same cycle.

Top module: `acc6_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the block goes to fetch step 1 and clears PC and the accumulator. In the cycle after reset is released, `pc_q` = 0, `acc_q` = 0 and `at_fetch` = 1. Reset is synchronous, and it takes effect even in the middle of an instruction.
- R2: In fetch step 2, `mem_addr` equals the PC of the instruction being fetched. PC increases by exactly one per fetch, modulo 64. PC changes in no other step, except the relative jump.
- R3: The opcode is bits 7:6 of the instruction byte and the operand address is bits 5:0. In the first execute step, `mem_addr` carries the operand address.
- R4: Opcode 00 (invert) sets AC to the bitwise NOT of AC. The whole instruction takes 4 clock cycles.
- R5: Opcode 01 (relative jump) reads the byte at the operand address. It then sets PC to the already-incremented PC plus bits 5:0 of that byte, modulo 64. Bits 7:6 of the byte are ignored and AC is unchanged. The instruction takes 5 cycles.
- R6: Opcode 10 (OR) sets AC to AC OR the byte at the operand address, in 5 cycles.
- R7: Opcode 11 (complement-add) sets AC to (AC + NOT byte) modulo 256, with no carry-in, in 5 cycles.
- R8: After the last execute step, control always returns to fetch step 1. `at_fetch` is high exactly in fetch step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 6 | Memory read address (address register) |
| mem_rdata | input | 8 | Memory read data for `mem_addr`, valid in the same cycle |
| acc_q | output | 8 | Current accumulator value |
| pc_q | output | 6 | Current program counter |
| at_fetch | output | 1 | High while the processor is in fetch step 1 |

## Verification
The assertions assume that `mem_rdata` is a known value in every cycle where it is loaded. They also assume that the read data belongs to the address currently on `mem_addr`, with no latency.

The bench meets both assumptions:
- Every byte of its 64-entry memory is initialised before reset is released.
- It drives read data combinationally from the address.
- It holds reset for several cycles, so every register starts from a known value before any property is checked.

// File: rtl/acc6_pkg.sv
package acc6_pkg;

    localparam int OPC_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_INV  = 2'b00,
        OP_JREL = 2'b01,
        OP_OR   = 2'b10,
        OP_CADD = 2'b11
    } opcode_e;

    typedef enum logic [2:0] {
        ST_F1 = 3'd0,
        ST_F2 = 3'd1,
        ST_F3 = 3'd2,
        ST_X1 = 3'd3,
        ST_X2 = 3'd4
    } step_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_NOT  = 2'd1,
        ALU_OR   = 2'd2,
        ALU_ADDN = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic    ar_from_pc;
        logic    dr_load;
        logic    pc_inc;
        logic    pc_rel;
        logic    split_load;
        logic    ac_load;
        alu_op_e alu;
    } ctrl_t;

    // Opcodes whose work is done in the first execute step.
    function automatic logic single_exec(opcode_e op);
        return op == OP_INV;
    endfunction

    function automatic alu_op_e alu_for(opcode_e op);
        case (op)
            OP_INV:  return ALU_NOT;
            OP_OR:   return ALU_OR;
            OP_CADD: return ALU_ADDN;
            default: return ALU_PASS;
        endcase
    endfunction

endpackage

// File: rtl/acc6_alu.sv
module acc6_alu
    import acc6_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            ALU_NOT:  y = ~a;
            ALU_OR:   y = a | b;
            ALU_ADDN: y = a + ~b;   // one's-complement add, no carry-in
            default:  y = b;
        endcase
    end
endmodule

// File: rtl/acc6_ctrl.sv
module acc6_ctrl
    import acc6_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e ir,
    output step_e   step,
    output ctrl_t   ctl
);
    step_e step_nx;

    always_ff @(posedge clk) begin
        if (rst) step <= ST_F1;
        else     step <= step_nx;
    end

    always_comb begin
        case (step)
            ST_F1:   step_nx = ST_F2;
            ST_F2:   step_nx = ST_F3;
            ST_F3:   step_nx = ST_X1;
            ST_X1:   step_nx = single_exec(ir) ? ST_F1 : ST_X2;
            default: step_nx = ST_F1;
        endcase
    end

    always_comb begin
        ctl = '0;
        ctl.alu = alu_for(ir);
        case (step)
            ST_F1: ctl.ar_from_pc = 1'b1;
            ST_F2: begin
                ctl.dr_load = 1'b1;
                ctl.pc_inc  = 1'b1;
            end
            ST_F3: ctl.split_load = 1'b1;
            ST_X1: begin
                if (single_exec(ir)) ctl.ac_load = 1'b1;
                else                 ctl.dr_load = 1'b1;
            end
            ST_X2: begin
                if (ir == OP_JREL) ctl.pc_rel  = 1'b1;
                else               ctl.ac_load = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc6_cpu.sv
module acc6_cpu
    import acc6_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic [ADDR_W+OPC_W-1:0]    mem_rdata,
    output logic [ADDR_W+OPC_W-1:0]    acc_q,
    output logic [ADDR_W-1:0]          pc_q,
    output logic                       at_fetch
);
    localparam int DATA_W = ADDR_W + OPC_W;

    logic [ADDR_W-1:0] pc, ar;
    logic [DATA_W-1:0] ac, dr, alu_y;
    opcode_e           ir;
    step_e             step;
    ctrl_t             ctl;

    acc6_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .ir   (ir),
        .step (step),
        .ctl  (ctl)
    );

    acc6_alu #(.W(DATA_W)) u_alu (
        .op (ctl.alu),
        .a  (ac),
        .b  (dr),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ar <= '0;
            ac <= '0;
            dr <= '0;
            ir <= OP_INV;
        end else begin
            if (ctl.ar_from_pc) ar <= pc;
            if (ctl.dr_load)    dr <= mem_rdata;
            if (ctl.pc_inc)     pc <= pc + ADDR_W'(1);
            else if (ctl.pc_rel) pc <= pc + dr[ADDR_W-1:0];
            if (ctl.split_load) begin
                ir <= opcode_e'(dr[DATA_W-1 -: OPC_W]);
                ar <= dr[ADDR_W-1:0];
            end
            if (ctl.ac_load)    ac <= alu_y;
        end
    end

    assign mem_addr = ar;
    assign acc_q    = ac;
    assign pc_q     = pc;
    assign at_fetch = (step == ST_F1);
endmodule

// File: rtl/acc6_chk.sv
module acc6_chk
    import acc6_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input step_e         step,
    input opcode_e       ir,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] ar,
    input logic [DW-1:0] ac,
    input logic [DW-1:0] dr
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: first cycle after reset release
    always_ff @(posedge clk) begin
        if (rst_d === 1'b1 && rst === 1'b0)
            a_r1_reset_state: assert (pc == '0 && ac == '0 && step == ST_F1);
    end

    a_r2_ar_gets_pc: assert property (@(posedge clk) disable iff (rst)
        step == ST_F1 |=> ar == $past(pc));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        step == ST_F2 |=> pc == AW'($past(pc) + AW'(1)));

    a_r2_pc_stable: assert property (@(posedge clk) disable iff (rst)
        !(step == ST_F2 || step == ST_X2) |=> $stable(pc));

    a_r3_split: assert property (@(posedge clk) disable iff (rst)
        step == ST_F3 |=> (ir == $past(dr[DW-1:DW-2]) && ar == $past(dr[AW-1:0])));

    a_r4_invert: assert property (@(posedge clk) disable iff (rst)
        (step == ST_X1 && ir == OP_INV) |=> ac == ~$past(ac));

    a_r5_rel_jump: assert property (@(posedge clk) disable iff (rst)
        (step == ST_X2 && ir == OP_JREL) |=> pc == AW'($past(pc) + $past(dr[AW-1:0])));

    a_r8_back_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (step == ST_X2 || (step == ST_X1 && ir == OP_INV)) |=> step == ST_F1);
endmodule

bind acc6_cpu acc6_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .ir   (ir),
    .pc   (pc),
    .ar   (ar),
    .ac   (ac),
    .dr   (dr)
);

// File: tb/acc6_cpu_tb.sv
module acc6_cpu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    // {start pc, expected acc, expected pc, expected cycles}
    localparam logic [23:0] VEC [NVEC] = '{
        {6'd0,  8'h5A, 6'd1,  4'd5},   // R6 OR
        {6'd1,  8'hA5, 6'd2,  4'd4},   // R4 invert
        {6'd2,  8'h7F, 6'd3,  4'd5},   // R7 complement-add
        {6'd3,  8'hFF, 6'd4,  4'd5},   // R6
        {6'd4,  8'hFF, 6'd5,  4'd5},   // R7 with operand FF
        {6'd5,  8'h00, 6'd6,  4'd4},   // R4
        {6'd6,  8'h00, 6'd12, 4'd5},   // R5 forward jump
        {6'd12, 8'hFF, 6'd13, 4'd5},   // R7 with operand 00
        {6'd13, 8'hFF, 6'd1,  4'd5},   // R5 wrap, top bits ignored
        {6'd1,  8'h00, 6'd2,  4'd4},   // R4
        {6'd2,  8'hDA, 6'd3,  4'd5}    // R7
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] mem_addr;
    logic [7:0] mem_rdata;
    logic [7:0] acc_q;
    logic [5:0] pc_q;
    logic       at_fetch;
    logic [7:0] mem [64];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign mem_rdata = mem[mem_addr];

    acc6_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .acc_q     (acc_q),
        .pc_q      (pc_q),
        .at_fetch  (at_fetch)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        mem[0]  = 8'hA0; mem[1]  = 8'h00; mem[2]  = 8'hE1; mem[3]  = 8'hA2;
        mem[4]  = 8'hE3; mem[5]  = 8'h00; mem[6]  = 8'h64;
        mem[12] = 8'hE5; mem[13] = 8'h66;
        mem[32] = 8'h5A; mem[33] = 8'h25; mem[34] = 8'h80; mem[35] = 8'hFF;
        mem[36] = 8'h05; mem[37] = 8'h00; mem[38] = 8'hF3;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // The first cycle after release has been clocked once: F1 -> F2.
        // Check the reset state directly instead, before release, below.
        finish_run_guard();
    end

    task automatic finish_run_guard();
        // Restart from a clean reset to observe the reset state itself.
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc", 32'(pc_q), 32'd0);
        chk("R1 acc", 32'(acc_q), 32'd0);
        chk("R1 at_fetch", 32'(at_fetch), 32'd1);

        for (int v = 0; v < NVEC; v++) begin
            int cyc;
            @(negedge clk);
            cyc = 1;
            chk("R2 fetch address", 32'(mem_addr), 32'(VEC[v][23:18]));
            chk("R8 at_fetch low", 32'(at_fetch), 32'd0);
            while (!at_fetch && cyc < 20) begin
                @(negedge clk);
                cyc++;
            end
            chk("R4-7 acc", 32'(acc_q), 32'(VEC[v][17:10]));
            chk("R2/R5 pc", 32'(pc_q), 32'(VEC[v][9:4]));
            chk("R8 cycle count", 32'(cyc), 32'(VEC[v][3:0]));
        end

        // R9 mid-instruction reset (R1)
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset pc", 32'(pc_q), 32'd0);
        chk("R1 mid reset acc", 32'(acc_q), 32'd0);
        chk("R1 mid reset at_fetch", 32'(at_fetch), 32'd1);

        // R3: operand address on mem_addr in first execute step
        repeat (3) @(negedge clk);
        chk("R3 operand address", 32'(mem_addr), 32'h20);
        repeat (2) @(negedge clk);
        chk("R6 acc after reset", 32'(acc_q), 32'h5A);
        chk("R8 back at fetch", 32'(at_fetch), 32'd1);

        finish_run();
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
            finish_run();
        end
    end
endmodule